// File: doc/BRIEF.md
# Cross-Clock Timer Register Update Bridge

This block sits between a register port on the system bus clock and the five registers of an 8-bit timer: the counter, two compare values and two control registers. A second clock input carries a slow, free-running timer clock. A select bit in the block's status register chooses which clock the timer registers run from. When the bus clock is selected, a register write reaches the timer on the next bus edge. When the timer clock is selected, each write is first captured in a holding register on the bus side. A toggle request then crosses into the timer domain through a two-flop synchronizer. The timer side loads the held value and returns an acknowledge toggle through a second two-flop synchronizer.

Each register has its own busy flag, and software can read all five in the status register. A flag is set by an accepted write in timer-clock mode and stays set until the acknowledge comes back. Writing a register whose flag is still set raises a one-cycle error pulse, and the write is discarded. Changing the clock select clears every busy flag and every holding register. The status register also holds an external-clock enable, which turns off the crystal oscillator enable output.

Top module: `tmr_br_top`

## Requirements
- R1: Address map on `addr`: 0 status, 1 counter, 2 compare A, 3 compare B, 4 control A, 5 control B. Addresses 6 and 7 read zero and ignore writes. Status layout: bit 7 always reads 0, bit 6 is the external-clock enable, bit 5 is the clock select (1 = timer clock), bits 4..0 are the busy flags of counter, compare A, compare B, control A and control B in that order. Reset value is 0x00.
- R2: With select 0, a write to timer register k appears on its timer output after the next bus clock edge, and all busy flags stay 0.
- R3: With select 1, an accepted write to register k sets its busy flag, which reads as 1 right after the write edge.
- R4: With select 1 and a timer clock period of r bus periods, the busy flag reads 0 for the first time after bus edge n, counted from the write edge, with 2r+3 <= n <= 3r+3. The timer output then holds the written value, and the holding register does not change while the flag is set.
- R5: A write to a register whose busy flag is set makes `wr_err` high for exactly the bus cycle after that write edge. The write is discarded, and the earlier value still reaches the timer.
- R6: A write that changes the clock select clears all five busy flags and all holding registers in the same cycle. A compare read in timer-clock mode then returns 0.
- R7: `osc_en` is the inverse of the external-clock enable bit, so it is 1 after reset.
- R8: A counter read returns the timer-side counter through a two-flop bus-clock synchronizer when select is 1, and returns it directly when select is 0.
- R9: A compare or control read returns the last accepted write value, which is the holding register when select is 1 and the timer register when select is 0.
- R10: Busy flags are independent. A write to a free register is accepted while another register is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus / I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| clk_tmr | input | 1 | Asynchronous timer clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| wr_err | output | 1 | One-cycle pulse on a write to a busy register |
| osc_en | output | 1 | Crystal oscillator enable |
| tmr_clk | output | 1 | Clock the timer registers currently run from |
| tmr_cnt | output | 8 | Timer-side counter register |
| tmr_cmp_a | output | 8 | Timer-side compare A |
| tmr_cmp_b | output | 8 | Timer-side compare B |
| tmr_ctl_a | output | 8 | Timer-side control A |
| tmr_ctl_b | output | 8 | Timer-side control B |

## Verification
The assertions are sampled on the bus clock and assume that the select bit changes only through a status write. They also assume that no register write arrives in the same cycle as a select change, which the single address port guarantees. They further assume the timer clock never has an edge that coincides with a bus edge. The stimulus keeps to this by starting the timer clock on an offset of 3 ns and by using only half-periods that are multiples of 5 ns. All writes are driven and all samples taken on bus falling edges, and the external-clock enable is written before the select bit is set.

// File: rtl/tmr_br_pkg.sv
package tmr_br_pkg;
    localparam int NREG = 5;
    localparam int AW   = 3;

    // Register addresses; timer register k sits at address k+1
    localparam logic [AW-1:0] ADR_STAT = 3'd0;
    localparam logic [AW-1:0] ADR_CNT  = 3'd1;

    // Status bit positions
    localparam int ST_EXT = 6;
    localparam int ST_SEL = 5;
endpackage

// File: rtl/tmr_br_sync.sv
module tmr_br_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_br_bus.sv
module tmr_br_bus
    import tmr_br_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wr_data,
    input  logic [NREG-1:0]          ack_s,
    output logic                     sel,
    output logic                     ext,
    output logic [NREG-1:0]          busy,
    output logic [NREG-1:0]          req,
    output logic [NREG-1:0][DW-1:0]  hold,
    output logic                     err
);
    typedef struct packed {
        logic                    sel;
        logic                    ext;
        logic [NREG-1:0]         busy;
        logic [NREG-1:0]         req;
        logic [NREG-1:0][DW-1:0] hold;
        logic                    err;
    } bus_st_t;

    bus_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        // acknowledge returned: the timer domain took the value
        for (int i = 0; i < NREG; i++) begin
            if (s_q.busy[i] && (ack_s[i] == s_q.req[i])) s_d.busy[i] = 1'b0;
        end
        if (wr_en) begin
            if (addr == ADR_STAT) begin
                s_d.ext = wr_data[ST_EXT];
                s_d.sel = wr_data[ST_SEL];
                if (wr_data[ST_SEL] != s_q.sel) begin
                    s_d.busy = '0;
                    s_d.hold = '0;
                end
            end
            for (int i = 0; i < NREG; i++) begin
                if (addr == AW'(i + 1)) begin
                    if (!s_q.sel) begin
                        s_d.hold[i] = wr_data;
                    end else if (s_q.busy[i]) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.hold[i] = wr_data;
                        s_d.busy[i] = 1'b1;
                        s_d.req[i]  = ~s_q.req[i];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sel  = s_q.sel;
    assign ext  = s_q.ext;
    assign busy = s_q.busy;
    assign req  = s_q.req;
    assign hold = s_q.hold;
    assign err  = s_q.err;
endmodule

// File: rtl/tmr_br_tside.sv
module tmr_br_tside
    import tmr_br_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                     tclk,
    input  logic                     rst_n,
    input  logic [NREG-1:0]          req_s,
    input  logic [NREG-1:0][DW-1:0]  hold,
    input  logic [NREG-1:0]          ld_now,
    input  logic [DW-1:0]            ld_data,
    output logic [NREG-1:0][DW-1:0]  regs,
    output logic [NREG-1:0]          ack
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic [NREG-1:0]         ack;
    } tside_st_t;

    tside_st_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        for (int i = 0; i < NREG; i++) begin
            // new request toggle seen: load held value and answer
            if (req_s[i] != t_q.ack[i]) begin
                t_d.regs[i] = hold[i];
                t_d.ack[i]  = req_s[i];
            end
            // bus-clock mode: direct same-clock load
            if (ld_now[i]) t_d.regs[i] = ld_data;
        end
    end

    always_ff @(posedge tclk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign regs = t_q.regs;
    assign ack  = t_q.ack;
endmodule

// File: rtl/tmr_br_top.sv
module tmr_br_top
    import tmr_br_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_bus,
    input  logic          rst_n,
    input  logic          clk_tmr,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          wr_err,
    output logic          osc_en,
    output logic          tmr_clk,
    output logic [DW-1:0] tmr_cnt,
    output logic [DW-1:0] tmr_cmp_a,
    output logic [DW-1:0] tmr_cmp_b,
    output logic [DW-1:0] tmr_ctl_a,
    output logic [DW-1:0] tmr_ctl_b
);
    logic                    sel, ext;
    logic [NREG-1:0]         busy, req, req_s, ack, ack_s, ld_now;
    logic [NREG-1:0][DW-1:0] hold, regs;
    logic [DW-1:0]           cnt_s;

    tmr_br_bus #(.DW(DW)) u_bus (
        .clk(clk_bus), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .ack_s(ack_s), .sel(sel), .ext(ext),
        .busy(busy), .req(req), .hold(hold), .err(wr_err)
    );

    assign tmr_clk = sel ? clk_tmr : clk_bus;

    tmr_br_sync #(.W(NREG), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk(tmr_clk), .rst_n(rst_n), .din(req), .dout(req_s)
    );

    tmr_br_sync #(.W(NREG), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk_bus), .rst_n(rst_n), .din(ack), .dout(ack_s)
    );

    tmr_br_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk_bus), .rst_n(rst_n), .din(regs[0]), .dout(cnt_s)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_ld
        assign ld_now[g] = !sel && wr_en && (addr == AW'(g + 1));
    end

    tmr_br_tside #(.DW(DW)) u_tside (
        .tclk(tmr_clk), .rst_n(rst_n), .req_s(req_s), .hold(hold),
        .ld_now(ld_now), .ld_data(wr_data), .regs(regs), .ack(ack)
    );

    always_comb begin
        rd_data = '0;
        if (addr == ADR_STAT) begin
            rd_data[7:0] = {1'b0, ext, sel, busy[0], busy[1], busy[2], busy[3], busy[4]};
        end else if (addr == ADR_CNT) begin
            rd_data = sel ? cnt_s : regs[0];
        end else begin
            for (int i = 1; i < NREG; i++) begin
                if (addr == AW'(i + 1)) rd_data = sel ? hold[i] : regs[i];
            end
        end
    end

    assign osc_en    = ~ext;
    assign tmr_cnt   = regs[0];
    assign tmr_cmp_a = regs[1];
    assign tmr_cmp_b = regs[2];
    assign tmr_ctl_a = regs[3];
    assign tmr_ctl_b = regs[4];
endmodule

// File: rtl/tmr_br_chk.sv
module tmr_br_chk
    import tmr_br_pkg::*;
#(
    parameter int DW = 8
) (
    input logic                     clk_bus,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [AW-1:0]            addr,
    input logic [DW-1:0]            wr_data,
    input logic                     wr_err,
    input logic                     sel,
    input logic [NREG-1:0]          busy,
    input logic [NREG-1:0][DW-1:0]  hold,
    input logic [NREG-1:0][DW-1:0]  regs
);
    for (genvar k = 0; k < NREG; k++) begin : g_reg
        assert_busy_set_R3: assert property (@(posedge clk_bus) disable iff (!rst_n)
            (wr_en && addr == AW'(k + 1) && sel && !busy[k]) |=> busy[k]);

        assert_err_pulse_R5: assert property (@(posedge clk_bus) disable iff (!rst_n)
            (wr_en && addr == AW'(k + 1) && sel && busy[k]) |=> wr_err);

        assert_drop_write_R5: assert property (@(posedge clk_bus) disable iff (!rst_n)
            (wr_en && addr == AW'(k + 1) && sel && busy[k]) |=> $stable(hold[k]));

        assert_hold_stable_R4: assert property (@(posedge clk_bus) disable iff (!rst_n)
            busy[k] |=> (!busy[k] || $stable(hold[k])));

        assert_sync_load_R2: assert property (@(posedge clk_bus) disable iff (!rst_n)
            (wr_en && addr == AW'(k + 1) && !sel) |=> (regs[k] == $past(wr_data)));
    end

    assert_sync_idle_R2: assert property (@(posedge clk_bus) disable iff (!rst_n)
        !sel |-> (busy == '0));

    assert_sel_clear_R6: assert property (@(posedge clk_bus) disable iff (!rst_n)
        (sel != $past(sel)) |-> (busy == '0 && hold == '0));

    assert_err_cause_R5: assert property (@(posedge clk_bus) disable iff (!rst_n)
        wr_err |-> ($past(wr_en) && $past(sel)));
endmodule

bind tmr_br_top tmr_br_chk #(.DW(DW)) u_chk (
    .clk_bus(clk_bus), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .wr_err(wr_err), .sel(sel), .busy(busy),
    .hold(hold), .regs(regs)
);

// File: tb/tmr_br_top_tb.sv
module tmr_br_top_tb;
    logic       clk_bus = 1'b0;
    logic       clk_tmr = 1'b0;
    logic       rst_n   = 1'b0;
    logic       wr_en   = 1'b0;
    logic [2:0] addr    = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data, tmr_cnt, tmr_cmp_a, tmr_cmp_b, tmr_ctl_a, tmr_ctl_b;
    logic       wr_err, osc_en, tmr_clk;

    int tclk_half = 15;
    int nchk = 0;
    int nfail = 0;

    always #5 clk_bus = ~clk_bus;
    initial begin
        #3;
        forever #(tclk_half) clk_tmr = ~clk_tmr;
    end

    tmr_br_top u_dut (
        .clk_bus(clk_bus), .rst_n(rst_n), .clk_tmr(clk_tmr), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .wr_err(wr_err),
        .osc_en(osc_en), .tmr_clk(tmr_clk), .tmr_cnt(tmr_cnt),
        .tmr_cmp_a(tmr_cmp_a), .tmr_cmp_b(tmr_cmp_b), .tmr_ctl_a(tmr_ctl_a),
        .tmr_ctl_b(tmr_ctl_b)
    );

    // {addr, data}: bus-clock mode writes, expected on output and read-back
    localparam logic [10:0] VEC [5] = '{
        {3'd1, 8'hA5}, {3'd2, 8'h3C}, {3'd3, 8'hF0}, {3'd4, 8'h0F}, {3'd5, 8'h81}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] tout(input logic [2:0] a);
        case (a)
            3'd1: return tmr_cnt;
            3'd2: return tmr_cmp_a;
            3'd3: return tmr_cmp_b;
            3'd4: return tmr_ctl_a;
            3'd5: return tmr_ctl_b;
            default: return 8'h00;
        endcase
    endfunction

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk_bus);
        wr_en = 1'b1; addr = a; wr_data = v;
        @(posedge clk_bus);
        #1;
        wr_en = 1'b0; addr = 3'd0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk_bus);
        addr = a;
        #1;
        v = rd_data;
        addr = 3'd0;
    endtask

    // timer-clock write and busy-window measurement; r = clock ratio
    task automatic xfer(input logic [2:0] a, input logic [7:0] v, input int r);
        int clr = -1;
        bus_wr(a, v);
        for (int k = 0; k <= 3 * r + 12; k++) begin
            @(negedge clk_bus);
            if (k == 0) chk("R3 busy set after write", rd_data[5 - a], 1);
            if (rd_data[5 - a] == 1'b0) begin
                clr = k;
                break;
            end
        end
        chk("R4 busy clear edge in window",
            (clr >= 2 * r + 3 && clr <= 3 * r + 3), 1);
        chk("R4 timer output after transfer", tout(a), v);
    endtask

    initial begin
        #1_000_000;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk_bus);
        rst_n = 1'b1;

        // reset state
        @(negedge clk_bus);
        chk("R1 status reset", rd_data, 8'h00);
        chk("R7 osc_en after reset", osc_en, 1);
        chk("R5 wr_err idle", wr_err, 0);
        chk("R2 counter output reset", tmr_cnt, 8'h00);

        // bus-clock mode vector walk
        foreach (VEC[i]) begin
            bus_wr(VEC[i][10:8], VEC[i][7:0]);
            @(negedge clk_bus);
            chk("R2 sync write visible next edge", tout(VEC[i][10:8]), VEC[i][7:0]);
            chk("R2 busy stays clear", rd_data, 8'h00);
            bus_rd(VEC[i][10:8], v);
            chk("R9 read-back in bus-clock mode", v, VEC[i][7:0]);
        end

        // unused address: ignored and reads zero
        bus_wr(3'd7, 8'hFF);
        bus_rd(3'd7, v);
        chk("R1 unused address reads 0", v, 8'h00);
        chk("R1 status untouched", rd_data, 8'h00);
        chk("R1 control B untouched", tmr_ctl_b, 8'h81);

        // external clock enable, reserved bit 7 reads zero
        bus_wr(3'd0, 8'hC0);
        @(negedge clk_bus);
        chk("R1 status reserved bit zero", rd_data, 8'h40);
        chk("R7 osc_en off with ext enable", osc_en, 0);

        // timer-clock mode, ratio 1:3
        bus_wr(3'd0, 8'h60);
        repeat (4) @(negedge clk_bus);
        chk("R1 status async idle", rd_data, 8'h60);
        xfer(3'd2, 8'h5A, 3);
        bus_rd(3'd2, v);
        chk("R9 compare A read in async", v, 8'h5A);

        // write while busy: error pulse, write dropped
        bus_wr(3'd3, 8'h11);
        bus_wr(3'd3, 8'h22);
        @(negedge clk_bus);
        chk("R5 error pulse", wr_err, 1);
        @(negedge clk_bus);
        chk("R5 error pulse one cycle", wr_err, 0);
        repeat (40) @(negedge clk_bus);
        chk("R5 dropped write, first value kept", tmr_cmp_b, 8'h11);

        // independent flags
        bus_wr(3'd1, 8'h33);
        bus_wr(3'd4, 8'h44);
        @(negedge clk_bus);
        chk("R10 no error on other register", wr_err, 0);
        chk("R10 both busy flags set", rd_data, 8'h72);
        repeat (40) @(negedge clk_bus);
        chk("R10 counter delivered", tmr_cnt, 8'h33);
        chk("R10 control A delivered", tmr_ctl_a, 8'h44);
        bus_rd(3'd1, v);
        chk("R8 counter read through synchronizer", v, 8'h33);

        // select change clears busy and holding state
        bus_wr(3'd2, 8'h77);
        bus_wr(3'd0, 8'h40);
        @(negedge clk_bus);
        chk("R6 busy cleared on select change", rd_data, 8'h40);
        repeat (20) @(negedge clk_bus);

        // back to timer-clock mode, ratio 1:7
        tclk_half = 35;
        repeat (20) @(negedge clk_bus);
        bus_wr(3'd0, 8'h60);
        repeat (4) @(negedge clk_bus);
        bus_rd(3'd2, v);
        chk("R6 holding register cleared", v, 8'h00);
        xfer(3'd5, 8'hC3, 7);
        xfer(3'd1, 8'h5E, 7);

        // back to bus-clock mode
        bus_wr(3'd0, 8'h40);
        repeat (4) @(negedge clk_bus);
        bus_wr(3'd1, 8'h99);
        @(negedge clk_bus);
        chk("R2 sync counter write", tmr_cnt, 8'h99);
        chk("R2 no busy in bus-clock mode", rd_data, 8'h40);
        bus_rd(3'd1, v);
        chk("R8 direct counter read", v, 8'h99);

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule